// File: doc/BRIEF.md
# Clock Mode and Power Controller

This block sets the pace of a small processor core and decides when its clocks may run. From the free-running oscillator clock it derives a machine-cycle tick, one every 12 oscillator periods in normal speed or one every 6 in double speed. A one-time fuse forces double speed. Without the fuse, a software bit picks the speed and may be changed at any moment. The block also qualifies the external reset pin against the machine-cycle length, so that short glitches never reset the core.

Two low-power states are offered. In idle, only the CPU clock is gated: peripherals, timers and interrupt logic keep running, and any enabled interrupt brings the core back. In power-down, the oscillator enable drops and every clock stops. Power-down ends either with the reset pin or, when wake-up is enabled, with an external interrupt that is enabled and set to level-sensitive and whose pin is driven low. In both cases the oscillator restarts and a settle counter of configurable length must expire before any clock is released. On an interrupt wake, the core resumes only once the pin has returned high. A qualified reset overrides every pending transition.

Top module: `clkpwr_ctrl`

## Requirements
- R1: With `fuse_dbl`=1 a machine cycle lasts 6 oscillator periods whatever `sw_dbl` holds. With `fuse_dbl`=0 it lasts 12 periods for `sw_dbl`=0 and 6 for `sw_dbl`=1.
- R2: While running or idle, `mc_tick` is high for exactly one cycle per machine cycle. A speed change takes effect at once: a count already at or beyond the new length wraps on the next edge.
- R3: `sys_rst` rises after `rst_pin` has been sampled high on two machine cycles of consecutive edges (24 in normal speed, 12 in double speed) while the oscillator is stable. It falls one cycle after the pin is sampled low. A shorter pulse has no effect.
- R4: A one-cycle `idle_req` in the running state drops `cpu_clk_en` while `per_clk_en`, `osc_en` and `mc_tick` continue. `any_irq` high in idle restores `cpu_clk_en` and pulses `wake_evt` for one cycle.
- R5: A one-cycle `pd_req` in the running state drops `osc_en`, `per_clk_en`, `cpu_clk_en` and `mc_tick`. When `pd_req` and `idle_req` arrive together, power-down wins.
- R6: In power-down, a pin of `ext_int_n` wakes the block only if `wake_en`=1, its bit of `ext_int_en`=1 and its bit of `ext_int_lvl`=1 (1 means level-sensitive), with the pin low (0). Any other combination leaves `osc_en` at 0.
- R7: On leaving power-down, `osc_en` rises and all clocks and ticks stay gated for exactly `STAB_CYCLES` cycles.
- R8: After the settle time of an interrupt wake, the clocks stay gated until no enabled level-sensitive pin is low. The block then resumes running and pulses `wake_evt` once.
- R9: `rst_pin` high in power-down restarts the oscillator. After the settle time the block runs with no `wake_evt`, and reset qualification then starts counting.
- R10: While `sys_rst` is high the block is running with `cpu_clk_en`=1, `mc_tick`=0 and `wake_evt`=0, and `idle_req`, `pd_req` and `any_irq` have no effect. This holds even when reset is qualified in idle or while waiting for a pin release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| rst_pin | input | 1 | External reset pin, active high |
| fuse_dbl | input | 1 | Nonvolatile double-speed fuse, 1 = programmed |
| sw_dbl | input | 1 | Software double-speed bit |
| idle_req | input | 1 | One-cycle idle request |
| pd_req | input | 1 | One-cycle power-down request |
| wake_en | input | 1 | Allows interrupt wake from power-down |
| any_irq | input | 1 | Some enabled interrupt is pending |
| ext_int_n | input | NUM_EXT | External interrupt pins, active low |
| ext_int_en | input | NUM_EXT | Per-pin interrupt enable |
| ext_int_lvl | input | NUM_EXT | Per-pin type, 1 = level-sensitive |
| mc_tick | output | 1 | One-cycle machine-cycle strobe |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| sys_rst | output | 1 | Qualified system reset |
| wake_evt | output | 1 | One-cycle resume-by-interrupt strobe |

## Verification
The tick is counted over fixed windows under each fuse and software-bit setting, which separates the 6 and 12 period rates. Switches made mid-count show whether the new length applies at once. Reset pulses one edge short of and longer than the limit, in both speeds, separate correct qualification from an off-by-one. Power-down is attempted with wake-enable off, with an edge-type pin, with a disabled pin and with a valid pin, so that each term of the wake condition is shown to matter. Reset is then raised in idle, in power-down and while a wake waits for its pin to be released, which shows that it overrides requests and wakes.

// File: rtl/clkpwr_pkg.sv
`timescale 1ns/1ps
// Package: shared state encoding for the clock mode and power controller.
// Assumes: nothing beyond IEEE 1800-2017.
package clkpwr_pkg;
    typedef enum logic [2:0] {
        PS_RUN    = 3'd0,
        PS_IDLE   = 3'd1,
        PS_DOWN   = 3'd2,
        PS_SETTLE = 3'd3,
        PS_HOLD   = 3'd4
    } pwr_state_e;
endpackage

// File: rtl/clkpwr_mode.sv
`timescale 1ns/1ps
// Module: clkpwr_mode
// Resolves the active speed from fuse and software bit, and provides the
// machine-cycle limit and the reset qualification limit (both minus one).
// Assumes: FAST_DIV < NORM_DIV, both at least 2.
module clkpwr_mode #(
    parameter int NORM_DIV = 12,
    parameter int FAST_DIV = 6,
    parameter int DW       = 4,
    parameter int RW       = 6
) (
    input  logic          fuse_dbl,
    input  logic          sw_dbl,
    output logic [DW-1:0] div_lim,
    output logic [RW-1:0] rst_lim
);
    localparam logic [DW-1:0] NORM_LIM  = DW'(NORM_DIV - 1);
    localparam logic [DW-1:0] FAST_LIM  = DW'(FAST_DIV - 1);
    localparam logic [RW-1:0] NORM_RLIM = RW'(2 * NORM_DIV - 1);
    localparam logic [RW-1:0] FAST_RLIM = RW'(2 * FAST_DIV - 1);

    logic dbl;

    // Fuse overrides the software bit; limits follow the chosen speed.
    always_comb begin
        dbl     = fuse_dbl | sw_dbl;
        div_lim = dbl ? FAST_LIM : NORM_LIM;
        rst_lim = dbl ? FAST_RLIM : NORM_RLIM;
    end
endmodule

// File: rtl/clkpwr_presc.sv
`timescale 1ns/1ps
// Module: clkpwr_presc
// Machine-cycle prescaler. Counts oscillator periods while enabled and
// strobes once at the limit. Cleared when stopped or when reset is held.
// Assumes: div_lim may change on any cycle; a count past it wraps at once.
module clkpwr_presc #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          clr,
    input  logic [DW-1:0] div_lim,
    output logic          tick
);
    logic [DW-1:0] cnt;
    logic          at_end;

    // Terminal count detection against the current limit.
    always_comb begin
        at_end = (cnt >= div_lim);
        tick   = run & at_end;
    end

    // Period counter with wrap, clear and stop.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !run) begin
            cnt <= '0;
        end else if (at_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/clkpwr_rstq.sv
`timescale 1ns/1ps
// Module: clkpwr_rstq
// Reset pin qualifier. Counts consecutive high samples while the oscillator
// is stable; reports a hit once the count spans two machine cycles.
// Assumes: rst_lim is at most 2^RW - 2 so saturation never hides a hit.
module clkpwr_rstq #(
    parameter int RW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rst_pin,
    input  logic          counting,
    input  logic [RW-1:0] rst_lim,
    output logic          hit,
    output logic          sys_rst
);
    logic [RW-1:0] hcnt;
    logic          sample;

    // Hit decision from the count so far plus this edge's sample.
    always_comb begin
        sample = rst_pin & counting;
        hit    = sample & (hcnt >= rst_lim);
    end

    // Saturating run-length counter of high samples.
    always_ff @(posedge clk) begin
        if (!rst_n || !sample) begin
            hcnt <= '0;
        end else if (hcnt != {RW{1'b1}}) begin
            hcnt <= hcnt + 1'b1;
        end
    end

    // Registered reset output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_rst <= 1'b0;
        end else begin
            sys_rst <= hit;
        end
    end
endmodule

// File: rtl/clkpwr_fsm.sv
`timescale 1ns/1ps
// Module: clkpwr_fsm
// Power state machine: run, idle, power-down, oscillator settle and
// pin-release hold. Drives the clock and oscillator enables and the wake
// strobe. A reset hit overrides every transition.
// Assumes: requests are one-cycle pulses; STAB_CYCLES >= 2.
module clkpwr_fsm
    import clkpwr_pkg::*;
#(
    parameter int NUM_EXT     = 2,
    parameter int STAB_CYCLES = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rst_hit,
    input  logic               rst_pin,
    input  logic               idle_req,
    input  logic               pd_req,
    input  logic               any_irq,
    input  logic               wake_en,
    input  logic [NUM_EXT-1:0] ext_int_n,
    input  logic [NUM_EXT-1:0] ext_int_en,
    input  logic [NUM_EXT-1:0] ext_int_lvl,
    output logic               cpu_en,
    output logic               run,
    output logic               osc_en,
    output logic               counting,
    output logic               wake_evt
);
    localparam int             SW      = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1;
    localparam logic [SW-1:0]  SC_LAST = SW'(STAB_CYCLES - 1);

    pwr_state_e         st, st_nx;
    logic [SW-1:0]      sc, sc_nx;
    logic               via_int, via_nx;
    logic               wake_nx;
    logic [NUM_EXT-1:0] pin_low;
    logic               any_low;

    // Per-pin qualification: enabled, level-sensitive and driven low.
    for (genvar gi = 0; gi < NUM_EXT; gi++) begin : g_pin
        assign pin_low[gi] = ext_int_en[gi] & ext_int_lvl[gi] & ~ext_int_n[gi];
    end

    // Reduce per-pin qualifiers.
    always_comb any_low = |pin_low;

    // Next-state logic with reset precedence.
    always_comb begin
        st_nx   = st;
        sc_nx   = sc;
        via_nx  = via_int;
        wake_nx = 1'b0;
        if (rst_hit) begin
            st_nx  = PS_RUN;
            sc_nx  = '0;
            via_nx = 1'b0;
        end else begin
            case (st)
                PS_RUN: begin
                    if (pd_req) begin
                        st_nx = PS_DOWN;
                    end else if (idle_req) begin
                        st_nx = PS_IDLE;
                    end
                end
                PS_IDLE: begin
                    if (any_irq) begin
                        st_nx   = PS_RUN;
                        wake_nx = 1'b1;
                    end
                end
                PS_DOWN: begin
                    if (rst_pin) begin
                        st_nx  = PS_SETTLE;
                        sc_nx  = '0;
                        via_nx = 1'b0;
                    end else if (wake_en && any_low) begin
                        st_nx  = PS_SETTLE;
                        sc_nx  = '0;
                        via_nx = 1'b1;
                    end
                end
                PS_SETTLE: begin
                    if (sc == SC_LAST) begin
                        st_nx = via_int ? PS_HOLD : PS_RUN;
                    end else begin
                        sc_nx = sc + 1'b1;
                    end
                end
                PS_HOLD: begin
                    if (!any_low) begin
                        st_nx   = PS_RUN;
                        wake_nx = 1'b1;
                    end
                end
                default: st_nx = PS_RUN;
            endcase
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= PS_RUN;
            sc       <= '0;
            via_int  <= 1'b0;
            wake_evt <= 1'b0;
        end else begin
            st       <= st_nx;
            sc       <= sc_nx;
            via_int  <= via_nx;
            wake_evt <= wake_nx;
        end
    end

    // Enables decoded from the state.
    always_comb begin
        cpu_en   = (st == PS_RUN);
        run      = (st == PS_RUN) || (st == PS_IDLE);
        osc_en   = (st != PS_DOWN);
        counting = (st != PS_DOWN) && (st != PS_SETTLE);
    end
endmodule

// File: rtl/clkpwr_ctrl.sv
`timescale 1ns/1ps
// Module: clkpwr_ctrl (top)
// Clock mode and power controller: machine-cycle tick, reset qualification,
// idle and power-down control with settle-timed oscillator restart.
// Assumes: clk is the oscillator clock; rst_n is a synchronous power-on reset.
module clkpwr_ctrl #(
    parameter int NUM_EXT     = 2,
    parameter int NORM_DIV    = 12,
    parameter int FAST_DIV    = 6,
    parameter int STAB_CYCLES = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rst_pin,
    input  logic               fuse_dbl,
    input  logic               sw_dbl,
    input  logic               idle_req,
    input  logic               pd_req,
    input  logic               wake_en,
    input  logic               any_irq,
    input  logic [NUM_EXT-1:0] ext_int_n,
    input  logic [NUM_EXT-1:0] ext_int_en,
    input  logic [NUM_EXT-1:0] ext_int_lvl,
    output logic               mc_tick,
    output logic               cpu_clk_en,
    output logic               per_clk_en,
    output logic               osc_en,
    output logic               sys_rst,
    output logic               wake_evt
);
    localparam int DW = $clog2(NORM_DIV);
    localparam int RW = $clog2(2 * NORM_DIV) + 1;

    logic [DW-1:0] div_lim;
    logic [RW-1:0] rst_lim;
    logic          rst_hit;
    logic          run;
    logic          counting;

    clkpwr_mode #(
        .NORM_DIV (NORM_DIV),
        .FAST_DIV (FAST_DIV),
        .DW       (DW),
        .RW       (RW)
    ) u_mode (
        .fuse_dbl (fuse_dbl),
        .sw_dbl   (sw_dbl),
        .div_lim  (div_lim),
        .rst_lim  (rst_lim)
    );

    clkpwr_rstq #(
        .RW (RW)
    ) u_rstq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rst_pin  (rst_pin),
        .counting (counting),
        .rst_lim  (rst_lim),
        .hit      (rst_hit),
        .sys_rst  (sys_rst)
    );

    clkpwr_presc #(
        .DW (DW)
    ) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .clr     (rst_hit),
        .div_lim (div_lim),
        .tick    (mc_tick)
    );

    clkpwr_fsm #(
        .NUM_EXT     (NUM_EXT),
        .STAB_CYCLES (STAB_CYCLES)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rst_hit     (rst_hit),
        .rst_pin     (rst_pin),
        .idle_req    (idle_req),
        .pd_req      (pd_req),
        .any_irq     (any_irq),
        .wake_en     (wake_en),
        .ext_int_n   (ext_int_n),
        .ext_int_en  (ext_int_en),
        .ext_int_lvl (ext_int_lvl),
        .cpu_en      (cpu_clk_en),
        .run         (run),
        .osc_en      (osc_en),
        .counting    (counting),
        .wake_evt    (wake_evt)
    );

    // Peripheral clock follows the prescaler run condition.
    always_comb per_clk_en = run;
endmodule

// File: rtl/clkpwr_ctrl_chk.sv
`timescale 1ns/1ps
// Module: clkpwr_ctrl_chk
// Port-level protocol checks for clkpwr_ctrl, attached by bind.
// Assumes: rst_n is held low for at least one clock at start.
module clkpwr_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic rst_pin,
    input logic mc_tick,
    input logic cpu_clk_en,
    input logic per_clk_en,
    input logic osc_en,
    input logic sys_rst,
    input logic wake_evt
);
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mc_tick |=> !mc_tick); // R2
    AST_RST_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> $past(rst_pin)); // R3
    AST_IDLE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> (per_clk_en && osc_en)); // R4
    AST_DOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (!per_clk_en && !cpu_clk_en && !mc_tick)); // R5
    AST_SETTLE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_en) |-> (!per_clk_en && !cpu_clk_en)); // R7
    AST_WAKE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> !wake_evt); // R8
    AST_WAKE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |-> cpu_clk_en); // R8
    AST_RST_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> (cpu_clk_en && !mc_tick && !wake_evt)); // R10
endmodule

bind clkpwr_ctrl clkpwr_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_pin    (rst_pin),
    .mc_tick    (mc_tick),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .osc_en     (osc_en),
    .sys_rst    (sys_rst),
    .wake_evt   (wake_evt)
);

// File: tb/clkpwr_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock, plus
// directed tick-rate windows.
module clkpwr_ctrl_tb;
    localparam int STAB = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rst_pin = 1'b0, fuse_dbl = 1'b0, sw_dbl = 1'b0;
    logic       idle_req = 1'b0, pd_req = 1'b0, wake_en = 1'b0, any_irq = 1'b0;
    logic [1:0] ext_int_n = 2'b11, ext_int_en = 2'b00, ext_int_lvl = 2'b00;
    logic       mc_tick, cpu_clk_en, per_clk_en, osc_en, sys_rst, wake_evt;

    int    n_cmp = 0, n_bad = 0, tick_seen = 0;
    string cur_req = "R4";

    // model state: 0 run, 1 idle, 2 down, 3 settle, 4 hold
    int m_st = 0, m_pc = 0, m_rc = 0, m_sc = 0;
    bit m_via = 0, m_wake = 0, m_srst = 0;

    always #2 clk = ~clk;

    clkpwr_ctrl #(.NUM_EXT(2), .STAB_CYCLES(STAB)) u_dut (
        .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .fuse_dbl(fuse_dbl),
        .sw_dbl(sw_dbl), .idle_req(idle_req), .pd_req(pd_req), .wake_en(wake_en),
        .any_irq(any_irq), .ext_int_n(ext_int_n), .ext_int_en(ext_int_en),
        .ext_int_lvl(ext_int_lvl), .mc_tick(mc_tick), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .osc_en(osc_en), .sys_rst(sys_rst), .wake_evt(wake_evt));

    function automatic int cur_div();
        return (fuse_dbl || sw_dbl) ? 6 : 12;
    endfunction

    function automatic bit pin_low();
        for (int i = 0; i < 2; i++)
            if (ext_int_en[i] && ext_int_lvl[i] && !ext_int_n[i]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_ticks(int cycles, int exp, string req);
        int t0;
        t0 = tick_seen;
        step(cycles);
        chk(req, "tick count", tick_seen - t0, exp);
    endtask

    // Reference model update at the edge, comparison shortly after.
    always @(posedge clk) begin
        int  dv;
        bit  cnt_ok, hit, runs;
        dv = cur_div();
        if (!rst_n) begin
            m_st = 0; m_pc = 0; m_rc = 0; m_sc = 0; m_via = 0; m_wake = 0; m_srst = 0;
        end else begin
            cnt_ok = (m_st != 2) && (m_st != 3);
            if (rst_pin && cnt_ok) m_rc++; else m_rc = 0;
            hit  = rst_pin && cnt_ok && (m_rc >= 2 * dv);
            runs = (m_st == 0) || (m_st == 1);
            if (hit || !runs) m_pc = 0;
            else m_pc = (m_pc >= dv - 1) ? 0 : m_pc + 1;
            m_wake = 0;
            if (hit) begin
                m_st = 0; m_via = 0; m_sc = 0;
            end else begin
                case (m_st)
                    0: if (pd_req) m_st = 2; else if (idle_req) m_st = 1;
                    1: if (any_irq) begin m_st = 0; m_wake = 1; end
                    2: if (rst_pin) begin m_st = 3; m_sc = 0; m_via = 0; end
                       else if (wake_en && pin_low()) begin m_st = 3; m_sc = 0; m_via = 1; end
                    3: if (m_sc == STAB - 1) m_st = m_via ? 4 : 0; else m_sc++;
                    4: if (!pin_low()) begin m_st = 0; m_wake = 1; end
                    default: m_st = 0;
                endcase
            end
            m_srst = hit;
        end
        #1;
        if (mc_tick === 1'b1) tick_seen++;
        chk(cur_req, "mc_tick", int'(mc_tick),
            int'(((m_st == 0) || (m_st == 1)) && (m_pc >= cur_div() - 1)));
        chk(cur_req, "cpu_clk_en", int'(cpu_clk_en), int'(m_st == 0));
        chk(cur_req, "per_clk_en", int'(per_clk_en), int'((m_st == 0) || (m_st == 1)));
        chk(cur_req, "osc_en", int'(osc_en), int'(m_st != 2));
        chk(cur_req, "sys_rst", int'(sys_rst), int'(m_srst));
        chk(cur_req, "wake_evt", int'(wake_evt), int'(m_wake));
    end

    task automatic pulse_pd();
        pd_req = 1'b1; step(1); pd_req = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        // R1: tick rate per fuse and software bit
        cur_req = "R1";
        step(5);  expect_ticks(120, 10, "R1");
        sw_dbl = 1'b1; step(5); expect_ticks(120, 20, "R1");
        fuse_dbl = 1'b1; sw_dbl = 1'b0; step(5); expect_ticks(120, 20, "R1");
        fuse_dbl = 1'b0;
        // R2: speed changes mid count
        cur_req = "R2";
        step(9); sw_dbl = 1'b1; step(13); sw_dbl = 1'b0; step(3);
        sw_dbl = 1'b1; step(2); sw_dbl = 1'b0; step(30);
        // R3: short and long reset pulses in both speeds
        cur_req = "R3";
        rst_pin = 1'b1; step(23); rst_pin = 1'b0; step(5);
        rst_pin = 1'b1; step(30); rst_pin = 1'b0; step(5);
        sw_dbl = 1'b1;
        rst_pin = 1'b1; step(11); rst_pin = 1'b0; step(3);
        rst_pin = 1'b1; step(16); rst_pin = 1'b0; step(5);
        sw_dbl = 1'b0;
        // R4: idle entry and interrupt exit
        cur_req = "R4";
        idle_req = 1'b1; step(1); idle_req = 1'b0; step(30);
        any_irq = 1'b1; step(1); any_irq = 1'b0; step(10);
        // R5: power-down wins over idle
        cur_req = "R5";
        pd_req = 1'b1; idle_req = 1'b1; step(1); pd_req = 1'b0; idle_req = 1'b0; step(20);
        // R6: invalid wake attempts
        cur_req = "R6";
        ext_int_en = 2'b11; ext_int_lvl = 2'b01;
        wake_en = 1'b0; ext_int_n = 2'b10; step(10); ext_int_n = 2'b11;
        wake_en = 1'b1; ext_int_n = 2'b01; step(10); ext_int_n = 2'b11;
        ext_int_en = 2'b10; ext_int_n = 2'b10; step(10); ext_int_n = 2'b11; step(2);
        // R7 then R8: valid wake, settle, release
        ext_int_en = 2'b11;
        cur_req = "R7"; ext_int_n = 2'b10; step(STAB + 2);
        cur_req = "R8"; step(20); ext_int_n = 2'b11; step(20);
        // R9: reset out of power-down
        cur_req = "R9";
        pulse_pd(); step(5); rst_pin = 1'b1; step(STAB + 40); rst_pin = 1'b0; step(10);
        // R10: reset overrides idle, requests and pending wakes
        cur_req = "R10";
        idle_req = 1'b1; step(1); idle_req = 1'b0; step(3);
        rst_pin = 1'b1; step(20); any_irq = 1'b1;
        for (int k = 0; k < 6; k++) begin
            pd_req = 1'b1; step(1); pd_req = 1'b0; idle_req = 1'b1; step(1); idle_req = 1'b0;
        end
        rst_pin = 1'b0; any_irq = 1'b0; step(10);
        pulse_pd(); step(3); ext_int_n = 2'b10; step(STAB + 5);
        rst_pin = 1'b1; step(40); rst_pin = 1'b0; step(5); ext_int_n = 2'b11; step(20);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule